// File: doc/BRIEF.md
# Field Region Pattern Sequencer

This block chooses, line by line, which of four vertical pulse patterns an image sensor readout uses. A field is split into as many as five consecutive line regions. A line counter measures the position inside the field. The counter returns to zero on a field-start strobe and advances by one on each line strobe. The current line number is compared against four programmable boundary line numbers. A fifth boundary is fixed at line 0. The result of this comparison is the active region index.

The region index does not store a pattern directly. Instead it reaches one through two lookups. Each region owns a pointer field, and that pointer picks one of five select fields. The chosen select field holds the 2-bit pattern number. The pattern number is registered on every line strobe. It is output together with a one-cycle line-start pulse for the downstream pulse generator, so the vertical timing can change from one readout stage to the next.

Top module: `vrs_top`

## Requirements
- R1: After reset, `pat_num` is 0, `line_go` is 0, and the line counter holds 0.
- R2: A `field_start` pulse resets the line counter to 0, so the next accepted line strobe plays line 0.
- R3: A `line_stb` accepted in cycle n gives `line_go` high for exactly cycle n+1, and `pat_num` changes to the new pattern in that same cycle. The line played is the counter value before the strobe, and the counter then advances.
- R4: The line counter is 8 bits wide and stops at 255. Every strobe after that plays line 255 again.
- R5: Region k (k = 0..4) covers the lines from boundary k up to one line before boundary k+1. Boundary 0 is line 0, and region 4 runs to the end of the field. Boundary k (k = 1..4) is `bnd_flat[8*(k-1) +: 8]`.
- R6: The active region is the highest k whose boundary is less than or equal to the line number. A boundary that is not greater than the one before it therefore leaves the earlier region empty.
- R7: The pattern played is select field `sel_flat[2*j +: 2]`, where j is the pointer `ptr_flat[3*k +: 3]` of the active region k.
- R8: A pointer value of 5, 6 or 7 uses select field 0.
- R9: When `field_start` and `line_stb` are high in the same cycle, the field start wins. The strobe is dropped, no `line_go` follows, and `pat_num` is unchanged.
- R10: `pat_num` changes only in the cycle that `line_go` is high. Configuration changes between strobes have no effect until the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| field_start | input | 1 | Field-start strobe, one cycle |
| line_stb | input | 1 | Line strobe, one cycle |
| bnd_flat | input | 32 | Programmable boundaries 1..4, 8 bits each |
| ptr_flat | input | 15 | Per-region pointer fields, 3 bits each |
| sel_flat | input | 10 | Select fields 0..4, 2 bits each |
| pat_num | output | 2 | Registered pattern number |
| line_go | output | 1 | One-cycle line-start pulse to the pulse generator |

## Verification
The bench builds the block with its default parameters: an 8-bit line counter, five regions and 2-bit patterns. With these values a run of about 300 line strobes is enough to reach the saturation point at line 255 and to stay there. The 8-bit boundaries are small enough to place boundaries that are equal, descending or at line 0, so empty regions and out-of-range pointers can be reached with short fields.

// File: rtl/vrs_pkg.sv
package vrs_pkg;
    localparam int DEF_LINE_W  = 8;
    localparam int DEF_REGIONS = 5;
    localparam int DEF_PAT_W   = 2;

    function automatic int idx_w(input int n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/vrs_line_ctr.sv
module vrs_line_ctr #(
    parameter int LINE_W = vrs_pkg::DEF_LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              field_start,
    input  logic              line_stb,
    output logic [LINE_W-1:0] line_now,
    output logic              adv
);
    localparam logic [LINE_W-1:0] LINE_MAX = {LINE_W{1'b1}};

    typedef struct packed {
        logic [LINE_W-1:0] cnt;
    } ctr_s;

    ctr_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        adv  = line_stb & ~field_start;
        if (field_start) begin
            st_d.cnt = '0;
        end else if (line_stb && st_q.cnt != LINE_MAX) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_now = st_q.cnt;

    AST_CTR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> (line_now == '0));  // R2
    AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !field_start && line_now != LINE_MAX) |=> (line_now == $past(line_now) + 1'b1));  // R4
    AST_CTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !field_start && line_now == LINE_MAX) |=> (line_now == LINE_MAX));  // R4
    AST_CTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!line_stb && !field_start) |=> $stable(line_now));  // R3
endmodule

// File: rtl/vrs_region_find.sv
module vrs_region_find #(
    parameter int LINE_W  = vrs_pkg::DEF_LINE_W,
    parameter int REGIONS = vrs_pkg::DEF_REGIONS,
    parameter int RGN_W   = vrs_pkg::idx_w(REGIONS)
) (
    input  logic [LINE_W-1:0]               line_now,
    input  logic [(REGIONS-1)*LINE_W-1:0]   bnd_flat,
    output logic [RGN_W-1:0]                rgn
);
    logic [REGIONS-1:0] reached;

    assign reached[0] = 1'b1;

    genvar gk;
    generate
        for (gk = 1; gk < REGIONS; gk++) begin : g_cmp
            assign reached[gk] = (line_now >= bnd_flat[LINE_W*(gk-1) +: LINE_W]);
        end
    endgenerate

    always_comb begin
        rgn = '0;
        for (int k = 1; k < REGIONS; k++) begin
            if (reached[k]) rgn = RGN_W'(k);
        end
    end
endmodule

// File: rtl/vrs_pattern_map.sv
module vrs_pattern_map #(
    parameter int REGIONS = vrs_pkg::DEF_REGIONS,
    parameter int PAT_W   = vrs_pkg::DEF_PAT_W,
    parameter int RGN_W   = vrs_pkg::idx_w(REGIONS),
    parameter int PTR_W   = vrs_pkg::idx_w(REGIONS)
) (
    input  logic [RGN_W-1:0]           rgn,
    input  logic [REGIONS*PTR_W-1:0]   ptr_flat,
    input  logic [REGIONS*PAT_W-1:0]   sel_flat,
    output logic [PAT_W-1:0]           pat
);
    localparam logic [PTR_W-1:0] PTR_LIM = PTR_W'(REGIONS);

    logic [PTR_W-1:0] ptr_raw;
    logic [PTR_W-1:0] sel_idx;

    always_comb begin
        ptr_raw = '0;
        for (int k = 0; k < REGIONS; k++) begin
            if (rgn == RGN_W'(k)) ptr_raw = ptr_flat[PTR_W*k +: PTR_W];
        end
        sel_idx = (ptr_raw < PTR_LIM) ? ptr_raw : '0;
        pat = '0;
        for (int j = 0; j < REGIONS; j++) begin
            if (sel_idx == PTR_W'(j)) pat = sel_flat[PAT_W*j +: PAT_W];
        end
    end
endmodule

// File: rtl/vrs_top.sv
module vrs_top #(
    parameter int LINE_W  = vrs_pkg::DEF_LINE_W,
    parameter int REGIONS = vrs_pkg::DEF_REGIONS,
    parameter int PAT_W   = vrs_pkg::DEF_PAT_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           field_start,
    input  logic                           line_stb,
    input  logic [(REGIONS-1)*LINE_W-1:0]  bnd_flat,
    input  logic [REGIONS*vrs_pkg::idx_w(REGIONS)-1:0] ptr_flat,
    input  logic [REGIONS*PAT_W-1:0]       sel_flat,
    output logic [PAT_W-1:0]               pat_num,
    output logic                           line_go
);
    localparam int RGN_W = vrs_pkg::idx_w(REGIONS);
    localparam int PTR_W = vrs_pkg::idx_w(REGIONS);

    typedef struct packed {
        logic [PAT_W-1:0] pat;
        logic             go;
    } out_s;

    out_s st_d, st_q;

    logic [LINE_W-1:0] line_now;
    logic              adv;
    logic [RGN_W-1:0]  rgn;
    logic [PAT_W-1:0]  pat_new;

    vrs_line_ctr #(.LINE_W(LINE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .field_start(field_start),
        .line_stb(line_stb), .line_now(line_now), .adv(adv)
    );

    vrs_region_find #(.LINE_W(LINE_W), .REGIONS(REGIONS), .RGN_W(RGN_W)) u_find (
        .line_now(line_now), .bnd_flat(bnd_flat), .rgn(rgn)
    );

    vrs_pattern_map #(.REGIONS(REGIONS), .PAT_W(PAT_W), .RGN_W(RGN_W), .PTR_W(PTR_W)) u_map (
        .rgn(rgn), .ptr_flat(ptr_flat), .sel_flat(sel_flat), .pat(pat_new)
    );

    always_comb begin
        st_d    = st_q;
        st_d.go = adv;
        if (adv) st_d.pat = pat_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pat_num = st_q.pat;
    assign line_go = st_q.go;

    AST_GO_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (line_stb && !field_start) |=> line_go);  // R3
    AST_NO_GO_ON_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !line_go);  // R9
    AST_PAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !line_go |-> $stable(pat_num));  // R10
    AST_REGION_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        rgn < RGN_W'(REGIONS));  // R5
endmodule

// File: tb/sim_vrs_top.sv
module sim_vrs_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        field_start = 1'b0;
    logic        line_stb = 1'b0;
    logic [31:0] bnd_flat;
    logic [14:0] ptr_flat;
    logic [9:0]  sel_flat;
    logic [1:0]  pat_num;
    logic        line_go;

    logic [7:0] bnd [1:4];
    logic [2:0] ptr [0:4];
    logic [1:0] sel [0:4];

    int tests = 0;
    int fails = 0;
    int exp_line = 0;
    logic [1:0] last_exp = 2'd0;
    logic [1:0] expq [$];
    bit done = 1'b0;

    always #5 clk = ~clk;

    always_comb begin
        for (int k = 1; k <= 4; k++) bnd_flat[8*(k-1) +: 8] = bnd[k];
        for (int k = 0; k < 5; k++) ptr_flat[3*k +: 3] = ptr[k];
        for (int k = 0; k < 5; k++) sel_flat[2*k +: 2] = sel[k];
    end

    vrs_top u0 (
        .clk(clk), .rst_n(rst_n), .field_start(field_start), .line_stb(line_stb),
        .bnd_flat(bnd_flat), .ptr_flat(ptr_flat), .sel_flat(sel_flat),
        .pat_num(pat_num), .line_go(line_go)
    );

    function automatic logic [1:0] model_pat(input int ln);
        int r = 0;
        int p;
        for (int k = 1; k <= 4; k++) if (ln >= int'(bnd[k])) r = k;
        p = int'(ptr[r]);
        if (p > 4) p = 0;
        return sel[p];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic start_field();
        @(negedge clk); field_start = 1'b1;
        @(negedge clk); field_start = 1'b0;
        exp_line = 0;
    endtask

    task automatic play_line();
        @(negedge clk);
        last_exp = model_pat(exp_line);
        expq.push_back(last_exp);
        line_stb = 1'b1;
        if (exp_line < 255) exp_line++;
        @(negedge clk); line_stb = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && line_go) begin
            if (expq.size() == 0) begin
                check("R3 unexpected line_go", 1, 0);
            end else begin
                check("R5/R6/R7 pattern", int'(pat_num), int'(expq.pop_front()));
            end
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            check("watchdog", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        bnd[1] = 8'd10; bnd[2] = 8'd20; bnd[3] = 8'd30; bnd[4] = 8'd40;
        ptr[0] = 3'd1; ptr[1] = 3'd2; ptr[2] = 3'd3; ptr[3] = 3'd4; ptr[4] = 3'd0;
        sel[0] = 2'd3; sel[1] = 2'd2; sel[2] = 2'd1; sel[3] = 2'd0; sel[4] = 2'd2;
        repeat (3) @(negedge clk);
        check("R1 pat after reset", int'(pat_num), 0);
        check("R1 go after reset", int'(line_go), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: first strobe without a field start plays line 0
        exp_line = 0;
        play_line();
        // R5 R7: ascending boundaries over a 50-line field
        start_field();
        for (int i = 0; i < 50; i++) play_line();
        // R2: restart mid-field, line 0 again
        start_field();
        for (int i = 0; i < 12; i++) play_line();
        // R6 R8: equal and descending boundaries, out-of-range pointers
        bnd[1] = 8'd5; bnd[2] = 8'd5; bnd[3] = 8'd3; bnd[4] = 8'd60;
        ptr[0] = 3'd5; ptr[1] = 3'd7; ptr[2] = 3'd6; ptr[3] = 3'd1; ptr[4] = 3'd2;
        sel[0] = 2'd1; sel[1] = 2'd3; sel[2] = 2'd0; sel[3] = 2'd2; sel[4] = 2'd0;
        start_field();
        for (int i = 0; i < 70; i++) play_line();
        // R6: boundary 1 at line 0 empties region 0
        bnd[1] = 8'd0; bnd[2] = 8'd4; bnd[3] = 8'd8; bnd[4] = 8'd12;
        ptr[0] = 3'd0; ptr[1] = 3'd1; ptr[2] = 3'd2; ptr[3] = 3'd3; ptr[4] = 3'd4;
        sel[0] = 2'd0; sel[1] = 2'd1; sel[2] = 2'd2; sel[3] = 2'd3; sel[4] = 2'd1;
        start_field();
        for (int i = 0; i < 16; i++) play_line();
        // R9: simultaneous field start and line strobe
        @(negedge clk); field_start = 1'b1; line_stb = 1'b1;
        @(negedge clk); field_start = 1'b0; line_stb = 1'b0;
        check("R9 no line_go on clash", int'(line_go), 0);
        check("R9 pat unchanged on clash", int'(pat_num), int'(last_exp));
        exp_line = 0;
        play_line();
        @(negedge clk);
        check("R3 line_go lasts one cycle", int'(line_go), 0);
        // R10: config changes between strobes do not reach pat_num
        sel[1] = ~sel[1]; sel[0] = ~sel[0]; bnd[1] = 8'd200;
        repeat (3) @(negedge clk);
        check("R10 pat held between strobes", int'(pat_num), int'(last_exp));
        play_line();
        // R4: saturation at line 255
        bnd[1] = 8'd100; bnd[2] = 8'd200; bnd[3] = 8'd250; bnd[4] = 8'd255;
        ptr[0] = 3'd0; ptr[1] = 3'd1; ptr[2] = 3'd2; ptr[3] = 3'd3; ptr[4] = 3'd4;
        sel[0] = 2'd0; sel[1] = 2'd1; sel[2] = 2'd2; sel[3] = 2'd1; sel[4] = 2'd3;
        start_field();
        for (int i = 0; i < 300; i++) play_line();
        repeat (3) @(negedge clk);
        check("R4 saturated line plays region 4", int'(pat_num), 3);
        check("R3 queue drained", expq.size(), 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule